// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block chooses the next fetch address for a processor that runs hardware DO-UNTIL loops without a branch instruction at the loop end. When a DO-UNTIL executes, the block saves the loop's end address and a 4-bit termination condition on a loop stack. At the same time it saves the address after the DO-UNTIL, which is the first instruction of the loop, on a parallel PC stack. Both stacks are four entries deep. While at least one loop is open, the block compares the address of the instruction now executing (`pc`) with the end address on top of the loop stack. On a match, it evaluates the stacked condition against the ALU and MAC flags and the counter-expired flag. It then either sends fetch back to the loop start or lets it fall through and closes the loop.

A taken explicit jump, call or return always wins, and every end-of-loop action is suppressed. An IDLE keeps fetch at the current address until an interrupt wakes it. A wake at the loop end closes the loop and continues after it. When the loop counter is the termination test, the block tells the counter logic to decrement on each loop-back and to pop its count stack on exit. A push onto full stacks is dropped and sets a sticky overflow flag.

Top module: `zol_sequencer`

## Requirements
- R1: After reset both stacks are empty, `ovf` is 0, and with no branch or idle the next address is `pc`+1 with `cnt_dec` and `cnt_pop` low.
- R2: A cycle with `loop_do` high pushes `loop_end` and `loop_cond` onto the loop stack and `pc`+1 onto the PC stack, so the first loop instruction is the one after the DO-UNTIL.
- R3: With the stacks empty, or with `pc` different from the top end address, the next address is `pc`+1 and no counter request is made.
- R4: At the loop end with the stacked condition false, the next address is the top of the PC stack, and `cnt_dec` is raised exactly when the condition code is 14 (CE). `cnt_dec` and `cnt_pop` are never high together.
- R5: At the loop end with the condition true, the next address is `pc`+1, both stacks are popped on that edge, and `cnt_pop` is raised exactly when the condition code is 14.
- R6: Condition codes, with X = AN xor AV: 0 AZ, 1 not AZ, 2 not (X or AZ), 3 X or AZ, 4 X, 5 not X, 6 AV, 7 not AV, 8 AC, 9 not AC, 10 AS, 11 not AS, 12 MV, 13 not MV, 14 `cnt_expired`, 15 never true (loop forever).
- R7: When `br_kind` is nonzero (1 jump, 2 call, 3 return) and `br_taken` is high, the next address is `br_target`, no pop occurs and neither counter request is raised, even at the loop end.
- R8: When `br_kind` is nonzero but `br_taken` is low, the loop end is handled as in R4 and R5.
- R9: With `idle_wait` high, the next address is `pc`. With `idle_wake` high at the loop end, the next address is `pc`+1 and the loop is closed whatever its condition.
- R10: Loops nest to four levels in last-in first-out order, and only the innermost loop's end address is compared.
- R11: A DO-UNTIL while four loops are open is discarded and sets `ovf`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | AW | Address of the instruction executing now |
| loop_do | input | 1 | Current instruction is a DO-UNTIL |
| loop_end | input | AW | End address carried by the DO-UNTIL |
| loop_cond | input | 4 | Termination condition code carried by the DO-UNTIL |
| flag_az | input | 1 | ALU zero |
| flag_an | input | 1 | ALU negative |
| flag_av | input | 1 | ALU overflow |
| flag_ac | input | 1 | ALU carry |
| flag_xs | input | 1 | ALU X input sign |
| flag_mv | input | 1 | MAC overflow |
| cnt_expired | input | 1 | Loop counter expired |
| br_kind | input | 2 | Explicit control instruction: 0 none, 1 jump, 2 call, 3 return |
| br_taken | input | 1 | The explicit instruction's own condition is true |
| br_target | input | AW | Destination of the explicit instruction |
| idle_wait | input | 1 | IDLE executing, no interrupt yet |
| idle_wake | input | 1 | Interrupt ends an IDLE |
| next_addr | output | AW | Next fetch address |
| cnt_dec | output | 1 | Request to decrement the loop counter |
| cnt_pop | output | 1 | Request to pop the count stack |
| ovf | output | 1 | Sticky stack overflow |

## Verification
For each of the sixteen condition codes, a single open loop is probed at its end address under all 128 combinations of the six status flags and the counter flag. The expected outcome comes from a pairwise formula, which separates every code from its complement and from its neighbours, and it also shows which code alone drives the counter requests. Nested loops show that only the innermost end is compared and that an exit brings back the outer loop's start. Taken and untaken explicit branches at the end show whether the override suppresses pops. IDLE holds and wakes, and a fifth push onto full stacks, show the sticky overflow and that the existing entries are left intact.

// File: rtl/zol_sequencer.sv
module zol_sequencer #(
  parameter int AW    = 14,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic          loop_do,
  input  logic [AW-1:0] loop_end,
  input  logic [3:0]    loop_cond,
  input  logic          flag_az,
  input  logic          flag_an,
  input  logic          flag_av,
  input  logic          flag_ac,
  input  logic          flag_xs,
  input  logic          flag_mv,
  input  logic          cnt_expired,
  input  logic [1:0]    br_kind,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic          idle_wait,
  input  logic          idle_wake,
  output logic [AW-1:0] next_addr,
  output logic          cnt_dec,
  output logic          cnt_pop,
  output logic          ovf
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [3:0] C_CE = 4'd14;

  logic [AW-1:0] end_stk [DEPTH];
  logic [3:0]    cnd_stk [DEPTH];
  logic [AW-1:0] pc_stk  [DEPTH];
  logic [LW-1:0] lvl;
  logic [IW-1:0] top;
  logic [AW-1:0] pc_inc;
  logic          at_end, br_take, term, loop_pop, full;
  logic [3:0]    cnd_top;

  assign top     = IW'(lvl - LW'(1));
  assign pc_inc  = pc + AW'(1);
  assign cnd_top = cnd_stk[top];
  assign at_end  = (lvl != '0) && (pc == end_stk[top]);
  assign br_take = (br_kind != 2'd0) && br_taken;
  assign full    = (lvl == LW'(DEPTH));

  function automatic logic cond_true(input logic [3:0] c, input logic az, an, av, ac,
                                     xs, mv, ce);
    logic x;
    x = an ^ av;
    case (c)
      4'd0:    cond_true = az;
      4'd1:    cond_true = !az;
      4'd2:    cond_true = !(x | az);
      4'd3:    cond_true = x | az;
      4'd4:    cond_true = x;
      4'd5:    cond_true = !x;
      4'd6:    cond_true = av;
      4'd7:    cond_true = !av;
      4'd8:    cond_true = ac;
      4'd9:    cond_true = !ac;
      4'd10:   cond_true = xs;
      4'd11:   cond_true = !xs;
      4'd12:   cond_true = mv;
      4'd13:   cond_true = !mv;
      4'd14:   cond_true = ce;
      default: cond_true = 1'b0;
    endcase
  endfunction

  assign term = cond_true(cnd_top, flag_az, flag_an, flag_av, flag_ac, flag_xs, flag_mv,
                          cnt_expired);

  always_comb begin
    next_addr = pc_inc;
    loop_pop  = 1'b0;
    cnt_dec   = 1'b0;
    cnt_pop   = 1'b0;
    if (br_take) begin
      next_addr = br_target;
    end else if (idle_wait) begin
      next_addr = pc;
    end else if (at_end) begin
      if (idle_wake || term) begin
        loop_pop = 1'b1;
        cnt_pop  = (cnd_top == C_CE);
      end else begin
        next_addr = pc_stk[top];
        cnt_dec   = (cnd_top == C_CE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl <= '0;
      ovf <= 1'b0;
    end else if (loop_do && loop_pop) begin
      end_stk[top] <= loop_end;
      cnd_stk[top] <= loop_cond;
      pc_stk[top]  <= pc_inc;
    end else if (loop_do) begin
      if (full) begin
        ovf <= 1'b1;
      end else begin
        end_stk[IW'(lvl)] <= loop_end;
        cnd_stk[IW'(lvl)] <= loop_cond;
        pc_stk[IW'(lvl)]  <= pc_inc;
        lvl <= lvl + LW'(1);
      end
    end else if (loop_pop) begin
      lvl <= lvl - LW'(1);
    end
  end
endmodule

// File: rtl/zol_sequencer_chk.sv
module zol_sequencer_chk #(
  parameter int AW    = 14,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc,
  input logic          loop_do,
  input logic [1:0]    br_kind,
  input logic          br_taken,
  input logic [AW-1:0] br_target,
  input logic          idle_wait,
  input logic [AW-1:0] next_addr,
  input logic          cnt_dec,
  input logic          cnt_pop,
  input logic          ovf,
  input logic          loop_pop,
  input logic [LW-1:0] lvl
);
  AST_BRANCH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind != 2'd0 && br_taken) |-> (next_addr == br_target && !cnt_dec && !cnt_pop && !loop_pop)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_wait && !(br_kind != 2'd0 && br_taken)) |-> next_addr == pc); // R9
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_dec && cnt_pop)); // R4
  AST_POP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_pop && !loop_do) |=> lvl == $past(lvl) - LW'(1)); // R5
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LW'(DEPTH)); // R10
  AST_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_do && !loop_pop && lvl == LW'(DEPTH)) |=> ovf); // R11
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R11
endmodule

bind zol_sequencer zol_sequencer_chk #(.AW(AW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc(pc), .loop_do(loop_do), .br_kind(br_kind),
  .br_taken(br_taken), .br_target(br_target), .idle_wait(idle_wait),
  .next_addr(next_addr), .cnt_dec(cnt_dec), .cnt_pop(cnt_pop), .ovf(ovf),
  .loop_pop(loop_pop), .lvl(lvl)
);

// File: tb/zol_sequencer_tb.sv
module zol_sequencer_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pc = '0, loop_end = '0, br_target = '0;
  logic          loop_do = 1'b0;
  logic [3:0]    loop_cond = '0;
  logic          flag_az = 0, flag_an = 0, flag_av = 0, flag_ac = 0, flag_xs = 0, flag_mv = 0;
  logic          cnt_expired = 0;
  logic [1:0]    br_kind = '0;
  logic          br_taken = 0, idle_wait = 0, idle_wake = 0;
  logic [AW-1:0] next_addr;
  logic          cnt_dec, cnt_pop, ovf;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  zol_sequencer #(.AW(AW), .DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .loop_do(loop_do), .loop_end(loop_end),
    .loop_cond(loop_cond), .flag_az(flag_az), .flag_an(flag_an), .flag_av(flag_av),
    .flag_ac(flag_ac), .flag_xs(flag_xs), .flag_mv(flag_mv), .cnt_expired(cnt_expired),
    .br_kind(br_kind), .br_taken(br_taken), .br_target(br_target),
    .idle_wait(idle_wait), .idle_wake(idle_wake), .next_addr(next_addr),
    .cnt_dec(cnt_dec), .cnt_pop(cnt_pop), .ovf(ovf)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  function automatic bit exp_term(input int c, input int f);
    bit az, an, av, ac, xs, mv, ce, s, b;
    az = f[0]; an = f[1]; av = f[2]; ac = f[3]; xs = f[4]; mv = f[5]; ce = f[6];
    s = an ^ av;
    if (c == 14) return ce;
    if (c == 15) return 0;
    case (c >> 1)
      0: b = az;
      1: b = !(s | az);
      2: b = s;
      3: b = av;
      4: b = ac;
      5: b = xs;
      6: b = mv;
      default: b = 0;
    endcase
    return b ^ bit'(c & 1);
  endfunction

  task automatic set_flags(input int f);
    flag_az = f[0]; flag_an = f[1]; flag_av = f[2]; flag_ac = f[3];
    flag_xs = f[4]; flag_mv = f[5]; cnt_expired = f[6];
  endtask

  task automatic reset_dut();
    rst_n = 0; loop_do = 0; br_kind = 0; br_taken = 0; idle_wait = 0; idle_wake = 0;
    set_flags(0);
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic do_loop(input int p, input int e, input int c);
    pc = AW'(p); loop_end = AW'(e); loop_cond = 4'(c); loop_do = 1;
    @(negedge clk);
    loop_do = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    reset_dut();
    // R1: reset state
    pc = 14'd20; #1;
    chk("R1 next", int'(next_addr), 21);
    chk("R1 ovf", int'(ovf), 0);
    chk("R1 dec", int'(cnt_dec), 0);
    chk("R1 pop", int'(cnt_pop), 0);
    pc = 14'd110; cnt_expired = 1; #1;
    chk("R3 empty", int'(next_addr), 111);
    cnt_expired = 0;
    @(negedge clk);

    // R2 R4 R5 R6 R8: every code against every flag pattern
    for (int c = 0; c < 16; c++) begin
      reset_dut();
      do_loop(100, 110, c);
      pc = 14'd105; #1;
      chk("R3 off_end", int'(next_addr), 106);
      for (int f = 0; f < 128; f++) begin
        set_flags(f);
        br_kind = 2'(f & 3); br_taken = 0;
        pc = 14'd110; #1;
        if (exp_term(c, f)) begin
          chk("R5 R6 exit", int'(next_addr), 111);
          chk("R5 cnt_pop", int'(cnt_pop), int'(c == 14));
          chk("R5 cnt_dec", int'(cnt_dec), 0);
        end else begin
          chk("R2 R4 R6 back", int'(next_addr), 101);
          chk("R4 cnt_dec", int'(cnt_dec), int'(c == 14));
          chk("R4 cnt_pop", int'(cnt_pop), 0);
        end
        pc = 14'd105; br_kind = 0;
        @(negedge clk);
      end
      set_flags(0);
    end

    // R5 R10: nested loops, only the inner end compared, exit restores outer
    reset_dut();
    do_loop(50, 90, 15);
    do_loop(60, 70, 0);
    pc = 14'd90; #1;
    chk("R10 outer_ignored", int'(next_addr), 91);
    pc = 14'd70; flag_az = 0; #1;
    chk("R10 inner_back", int'(next_addr), 61);
    flag_az = 1; #1;
    chk("R5 inner_exit", int'(next_addr), 71);
    @(negedge clk);
    flag_az = 0;
    pc = 14'd90; #1;
    chk("R5 R10 outer_back", int'(next_addr), 51);

    // R7: taken branch at loop end, no pop
    br_kind = 2'd1; br_taken = 1; br_target = 14'd300; #1;
    chk("R7 jump", int'(next_addr), 300);
    @(negedge clk);
    br_kind = 2'd3; br_taken = 0; #1;
    chk("R7 R8 no_pop", int'(next_addr), 51);
    br_kind = 0;

    // R9: idle hold then wake at the end
    idle_wait = 1; #1;
    chk("R9 hold", int'(next_addr), 90);
    idle_wait = 0; idle_wake = 1; #1;
    chk("R9 wake", int'(next_addr), 91);
    @(negedge clk);
    idle_wake = 0; #1;
    chk("R9 closed", int'(next_addr), 91);

    // R7: counter loop, taken branch suppresses counter requests
    reset_dut();
    do_loop(200, 210, 14);
    pc = 14'd210; cnt_expired = 1; br_kind = 2'd2; br_taken = 1; br_target = 14'd5; #1;
    chk("R7 no_pop", int'(cnt_pop), 0);
    cnt_expired = 0; #1;
    chk("R7 no_dec", int'(cnt_dec), 0);
    br_kind = 0; br_taken = 0; #1;
    chk("R4 ce_dec", int'(cnt_dec), 1);
    pc = 14'd205;
    @(negedge clk);

    // R11: overflow
    reset_dut();
    for (int k = 1; k <= 4; k++) do_loop(10 * k, 10 * k + 5, 15);
    #1;
    chk("R11 ovf_clear", int'(ovf), 0);
    do_loop(80, 85, 15);
    #1;
    chk("R11 ovf_set", int'(ovf), 1);
    pc = 14'd85; #1;
    chk("R11 dropped", int'(next_addr), 86);
    pc = 14'd45; #1;
    chk("R11 top_kept", int'(next_addr), 41);
    idle_wake = 1; #1;
    chk("R9 R10 wake_exit", int'(next_addr), 46);
    @(negedge clk);
    idle_wake = 0; pc = 14'd35; #1;
    chk("R10 lifo", int'(next_addr), 31);
    chk("R11 sticky", int'(ovf), 1);

    finish_run();
  end
endmodule